// File: doc/BRIEF.md
# Multiplexed External Memory Bus Cycle Sequencer

This block drives the external memory strobes and the multiplexed address/data ports of an 8-bit core with an external bus. Time is counted in oscillator periods. The block clocks once per period, and a machine cycle has twelve periods, numbered 0 to 11. At the last period of each machine cycle the core presents one request. That request then shapes the whole next machine cycle: idle, an opcode fetch of two consecutive bytes, an external data read, or an external data write.

The address latch strobe pulses twice per machine cycle, and the program-store strobe is low twice during a fetch. A data access keeps only the first latch pulse, drops both program-store pulses, and drives a single long read or write strobe. The low port carries the low address byte during the latch window. After that it either floats, so that an external device can return a byte, or it drives write data. The high port carries the upper address byte, or the port-latch byte that the core supplies with an 8-bit-address access. Returned bytes are captured on the rising edge of the read-type strobe and handed back to the core.

Top module: `xbus_seq`

## Requirements
- R1: The phase counter runs 0..11 and wraps. `mc_ready` is high exactly in phase 11. The request inputs are taken only at the clock edge that ends phase 11 while reset is low, and they have no effect in any other phase. `req_kind` is encoded 0 idle, 1 fetch, 2 data read, 3 data write.
- R2: `bus_ale` is high in phases 0-1 and 6-7 of every machine cycle that is not a data access, idle cycles included, and low in all other phases.
- R3: In a fetch cycle with address A, `bus_psen_n` is low in phases 3-5 while byte A is fetched and in phases 9-11 while byte A+1 is fetched (16-bit wrap). In every other phase and cycle type it is high.
- R4: In a data read or write cycle, `bus_ale` is high only in phases 0-1 (the pulse in phases 6-7 is suppressed) and `bus_psen_n` stays high for the whole cycle.
- R5: `bus_rd_n` is low in phases 5-10 of a read cycle and `bus_wr_n` is low in phases 5-10 of a write cycle. Both are high at all other times, including phase 11, one period before the next latch pulse.
- R6: `hi_out` carries bits 15:8 of the byte address being fetched in a fetch cycle (A in phases 0-5, A+1 in phases 6-11). In a data cycle with `req_wide`=1 it carries bits 15:8 of the data address. In a data cycle with `req_wide`=0, and in idle cycles, it carries the `req_p2` byte taken with the request. `req_wide` is ignored for fetches.
- R7: `lo_oe`=1 with `lo_out` = the low address byte in phases 0-2 of a fetch (A, then A+1 in phases 6-8) and in phases 0-2 of a data cycle. `lo_oe`=1 with `lo_out` = write data in phases 3-11 of a write. Otherwise `lo_oe`=0 and `lo_out`=0, so the port is released whenever the program-store or read strobe is low.
- R8: `lo_in` is captured in the last strobe-low phase (fetch phases 5 and 11, read phase 10). `rd_valid` is high for the one following period, with `rd_data` = the captured byte and `rd_code`=1 for fetched bytes and 0 for read data. `rd_data` and `rd_code` hold between captures.
- R9: While reset is high the sequencer sits in phase 11 of an idle cycle with a port byte of FF: `bus_ale`=0, all strobes high, `lo_oe`=0, `hi_out`=FF, `rd_valid`=0, `rd_data`=0, `rd_code`=0. A reset applied mid-cycle aborts the cycle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst | input | 1 | Synchronous active-high reset |
| req_kind | input | 2 | Cycle type for the next machine cycle |
| req_addr | input | 16 | Fetch or data address |
| req_wide | input | 1 | 1: 16-bit data address, 0: 8-bit data address |
| req_wdata | input | 8 | Write data byte |
| req_p2 | input | 8 | Port-latch byte for the high port |
| mc_ready | output | 1 | High in the last period of a machine cycle |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_psen_n | output | 1 | Program-store read strobe, active low |
| bus_rd_n | output | 1 | Data read strobe, active low |
| bus_wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low multiplexed port output value |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input value |
| hi_out | output | 8 | High port output value |
| rd_data | output | 8 | Last captured byte |
| rd_valid | output | 1 | One-period pulse after a capture |
| rd_code | output | 1 | Last captured byte came from a fetch |

## Verification
The bench aims at the boundaries between cycle types: a fetch at an address ending in FF, where the second byte must carry into the high port, and a fetch at FFFF, which must wrap to 0000. A design that forgot the carry, or used the base address for both halves, would show a wrong high byte in phases 6-11. Data cycles that follow fetches check that the second latch pulse and both program-store pulses disappear and that the strobe rises in phase 11. A design that counted the strobe from the wrong edge would overlap the next latch pulse. An 8-bit-address access with a port byte unlike the address exposes a design that steers address bits onto the high port. Garbage on the request inputs outside phase 11, and a reset at an arbitrary phase, catch requests that are sampled too often and cycles that survive a reset.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_AW = 16;
    localparam int XB_DW = 8;
    localparam int XB_HW = XB_AW - XB_DW;

    typedef enum logic [1:0] {
        XB_IDLE  = 2'd0,
        XB_FETCH = 2'd1,
        XB_READ  = 2'd2,
        XB_WRITE = 2'd3
    } xb_kind_e;

    // Request captured for the running machine cycle.
    typedef struct packed {
        xb_kind_e             kind;
        logic [XB_AW-1:0]     addr;
        logic                 wide;
        logic [XB_DW-1:0]     wdata;
        logic [XB_HW-1:0]     p2;
    } xb_desc_t;

    // Bus strobes as seen at the pins.
    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
    } xb_strobe_t;

    // Window flags that steer the ports and the capture register.
    typedef struct packed {
        logic addr_win;
        logic data_win;
        logic upper;
        logic cap;
    } xb_slot_t;

    function automatic logic xb_is_data(xb_kind_e k);
        return (k == XB_READ) || (k == XB_WRITE);
    endfunction

    function automatic xb_desc_t xb_idle_desc();
        xb_desc_t d;
        d.kind  = XB_IDLE;
        d.addr  = '0;
        d.wide  = 1'b0;
        d.wdata = '0;
        d.p2    = '1;
        return d;
    endfunction

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
    parameter int MC_LEN = 12,
    parameter int PH_W   = 4
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] LAST_P = PH_W'(MC_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= LAST_P;
        end else if (phase == LAST_P) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign last = (phase == LAST_P);
endmodule

// File: rtl/xbus_req_latch.sv
module xbus_req_latch
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [1:0]       kind,
    input  logic [XB_AW-1:0] addr,
    input  logic             wide,
    input  logic [XB_DW-1:0] wdata,
    input  logic [XB_HW-1:0] p2,
    output xb_desc_t         desc
);
    xb_desc_t nxt;

    always_comb begin
        nxt.kind  = xb_kind_e'(kind);
        nxt.addr  = addr;
        nxt.wide  = wide;
        nxt.wdata = wdata;
        nxt.p2    = p2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            desc <= xb_idle_desc();
        end else if (take) begin
            desc <= nxt;
        end
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int MC_LEN   = 12,
    parameter int ALE_LEN  = 2,
    parameter int PSEN_LEN = 3,
    parameter int STB_LEN  = 6,
    parameter int PH_W     = 4
) (
    input  logic [PH_W-1:0] phase,
    input  xb_kind_e        kind,
    output xb_strobe_t      strb,
    output xb_slot_t        slot
);
    // Half-cycle geometry: latch pulse, one period gap, program-store pulse.
    localparam logic [PH_W-1:0] HALF_P    = PH_W'(MC_LEN / 2);
    localparam logic [PH_W-1:0] ALE_END   = PH_W'(ALE_LEN);
    localparam logic [PH_W-1:0] ADDR_LAST = PH_W'(ALE_LEN);
    localparam logic [PH_W-1:0] PS_FIRST  = PH_W'(ALE_LEN + 1);
    localparam logic [PH_W-1:0] PS_LAST   = PH_W'(ALE_LEN + PSEN_LEN);
    // Data strobe: three periods after the latch falls, STB_LEN long.
    localparam logic [PH_W-1:0] ST_FIRST  = PH_W'(ALE_LEN + 3);
    localparam logic [PH_W-1:0] ST_LAST   = PH_W'(ALE_LEN + 2 + STB_LEN);

    logic            upper;
    logic [PH_W-1:0] hph;
    logic            fetch;
    logic            data;
    logic            stb_win;

    always_comb begin
        upper   = (phase >= HALF_P);
        hph     = upper ? (phase - HALF_P) : phase;
        fetch   = (kind == XB_FETCH);
        data    = xb_is_data(kind);
        stb_win = (phase >= ST_FIRST) && (phase <= ST_LAST);

        strb.ale    = (hph < ALE_END) && !(data && upper);
        strb.psen_n = !(fetch && (hph >= PS_FIRST) && (hph <= PS_LAST));
        strb.rd_n   = !((kind == XB_READ) && stb_win);
        strb.wr_n   = !((kind == XB_WRITE) && stb_win);

        slot.addr_win = (hph <= ADDR_LAST) && (fetch || (data && !upper));
        slot.data_win = (kind == XB_WRITE) && (phase > ADDR_LAST);
        slot.upper    = upper;
        slot.cap      = (fetch && (hph == PS_LAST)) ||
                        ((kind == XB_READ) && (phase == ST_LAST));
    end
endmodule

// File: rtl/xbus_port_mux.sv
module xbus_port_mux
    import xbus_pkg::*;
(
    input  xb_desc_t         desc,
    input  xb_slot_t         slot,
    output logic [XB_DW-1:0] lo_out,
    output logic             lo_oe,
    output logic [XB_HW-1:0] hi_out
);
    logic [XB_AW-1:0] byte_addr;

    always_comb begin
        // Second half of a fetch addresses the following byte.
        byte_addr = desc.addr + XB_AW'(slot.upper);

        if (desc.kind == XB_FETCH) begin
            hi_out = byte_addr[XB_AW-1:XB_DW];
        end else if (xb_is_data(desc.kind) && desc.wide) begin
            hi_out = desc.addr[XB_AW-1:XB_DW];
        end else begin
            hi_out = desc.p2;
        end

        if (slot.addr_win) begin
            lo_out = byte_addr[XB_DW-1:0];
            lo_oe  = 1'b1;
        end else if (slot.data_win) begin
            lo_out = desc.wdata;
            lo_oe  = 1'b1;
        end else begin
            lo_out = '0;
            lo_oe  = 1'b0;
        end
    end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             is_code,
    input  logic [XB_DW-1:0] lo_in,
    output logic [XB_DW-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_code  <= 1'b0;
        end else begin
            rd_valid <= cap;
            if (cap) begin
                rd_data <= lo_in;
                rd_code <= is_code;
            end
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int MC_LEN   = 12,
    parameter int ALE_LEN  = 2,
    parameter int PSEN_LEN = 3,
    parameter int STB_LEN  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       req_kind,
    input  logic [XB_AW-1:0] req_addr,
    input  logic             req_wide,
    input  logic [XB_DW-1:0] req_wdata,
    input  logic [XB_HW-1:0] req_p2,
    output logic             mc_ready,
    output logic             bus_ale,
    output logic             bus_psen_n,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic [XB_DW-1:0] lo_out,
    output logic             lo_oe,
    input  logic [XB_DW-1:0] lo_in,
    output logic [XB_HW-1:0] hi_out,
    output logic [XB_DW-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_code
);
    localparam int PH_W = $clog2(MC_LEN);

    logic [PH_W-1:0] phase;
    logic            last;
    xb_desc_t        desc;
    xb_strobe_t      strb;
    xb_slot_t        slot;

    xbus_phase_ctr #(.MC_LEN(MC_LEN), .PH_W(PH_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .last  (last)
    );

    xbus_req_latch u_req (
        .clk   (clk),
        .rst   (rst),
        .take  (last),
        .kind  (req_kind),
        .addr  (req_addr),
        .wide  (req_wide),
        .wdata (req_wdata),
        .p2    (req_p2),
        .desc  (desc)
    );

    xbus_strobe_gen #(
        .MC_LEN   (MC_LEN),
        .ALE_LEN  (ALE_LEN),
        .PSEN_LEN (PSEN_LEN),
        .STB_LEN  (STB_LEN),
        .PH_W     (PH_W)
    ) u_strb (
        .phase (phase),
        .kind  (desc.kind),
        .strb  (strb),
        .slot  (slot)
    );

    xbus_port_mux u_mux (
        .desc   (desc),
        .slot   (slot),
        .lo_out (lo_out),
        .lo_oe  (lo_oe),
        .hi_out (hi_out)
    );

    xbus_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap      (slot.cap),
        .is_code  (desc.kind == XB_FETCH),
        .lo_in    (lo_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_code  (rd_code)
    );

    assign mc_ready   = last;
    assign bus_ale    = strb.ale;
    assign bus_psen_n = strb.psen_n;
    assign bus_rd_n   = strb.rd_n;
    assign bus_wr_n   = strb.wr_n;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
    input logic clk,
    input logic rst,
    input logic mc_ready,
    input logic bus_ale,
    input logic bus_psen_n,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic lo_oe
);
    // R1: ready lasts a single period per machine cycle
    assert_ready_single_R1: assert property (@(posedge clk) disable iff (rst)
        mc_ready |=> !mc_ready);

    // R2: every latch pulse is at least two periods wide
    assert_ale_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ale) |=> bus_ale);

    // R2: no read-type or write strobe while the latch strobe is high
    assert_ale_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (bus_psen_n && bus_rd_n && bus_wr_n));

    // R5: read and write strobes never overlap each other or program-store
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        $countones({!bus_psen_n, !bus_rd_n, !bus_wr_n}) <= 1);

    // R5: a data strobe, once low, stays low the next period
    assert_rd_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_rd_n) |=> !bus_rd_n);

    // R7: low port released while program-store strobe is low
    assert_lo_free_psen_R7: assert property (@(posedge clk) disable iff (rst)
        !bus_psen_n |-> !lo_oe);

    // R7: low port released while the read strobe is low
    assert_lo_free_rd_R7: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !lo_oe);

    // R9: reset leaves every strobe inactive
    assert_reset_idle_R9: assert property (@(posedge clk)
        $past(rst) |-> (!bus_ale && bus_psen_n && bus_rd_n && bus_wr_n && !lo_oe));
endmodule

bind xbus_seq xbus_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mc_ready   (mc_ready),
    .bus_ale    (bus_ale),
    .bus_psen_n (bus_psen_n),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .lo_oe      (lo_oe)
);

// File: tb/xbus_seq_test.sv
module xbus_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic       req_wide = 1'b0;
    logic [7:0] req_wdata = 8'h0;
    logic [7:0] req_p2 = 8'h0;
    logic [7:0] lo_in = 8'h0;
    logic       mc_ready, bus_ale, bus_psen_n, bus_rd_n, bus_wr_n, lo_oe;
    logic [7:0] lo_out, hi_out, rd_data;
    logic       rd_valid, rd_code;

    always #4 clk = ~clk;

    xbus_seq uut (
        .clk(clk), .rst(rst), .req_kind(req_kind), .req_addr(req_addr),
        .req_wide(req_wide), .req_wdata(req_wdata), .req_p2(req_p2),
        .mc_ready(mc_ready), .bus_ale(bus_ale), .bus_psen_n(bus_psen_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .lo_out(lo_out),
        .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_code(rd_code)
    );

    typedef struct {
        int kind;
        int addr;
        int wide;
        int wdata;
        int p2;
    } rq_t;

    rq_t q[$];
    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // reference model state
    int  m_p;
    rq_t m_cur;
    int  m_vld, m_dat, m_code;
    bit  m_in_rst;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h phase=%0d", tag, what, act, exp, m_p);
        end
    endtask

    function automatic rq_t mk(int k, int a, int w, int d, int p);
        rq_t r;
        r.kind = k; r.addr = a; r.wide = w; r.wdata = d; r.p2 = p;
        return r;
    endfunction

    task automatic compare();
        int  h, hp, ba, e_ale, e_psen, e_rd, e_wr, e_oe, e_lo, e_hi;
        bit  fetch, data, aw;
        string t;
        h     = (m_p >= 6) ? 1 : 0;
        hp    = m_p % 6;
        fetch = (m_cur.kind == 1);
        data  = (m_cur.kind == 2) || (m_cur.kind == 3);
        ba    = (m_cur.addr + h) & 16'hFFFF;
        e_ale  = (hp < 2 && !(data && h == 1)) ? 1 : 0;
        e_psen = (fetch && hp >= 3) ? 0 : 1;
        e_rd   = (m_cur.kind == 2 && m_p >= 5 && m_p <= 10) ? 0 : 1;
        e_wr   = (m_cur.kind == 3 && m_p >= 5 && m_p <= 10) ? 0 : 1;
        aw     = (hp < 3) && (fetch || (data && h == 0));
        if (aw) begin
            e_oe = 1; e_lo = ba & 8'hFF;
        end else if (m_cur.kind == 3 && m_p >= 3) begin
            e_oe = 1; e_lo = m_cur.wdata;
        end else begin
            e_oe = 0; e_lo = 0;
        end
        if (fetch)                     e_hi = (ba >> 8) & 8'hFF;
        else if (data && m_cur.wide)   e_hi = (m_cur.addr >> 8) & 8'hFF;
        else                           e_hi = m_cur.p2;

        chk(m_in_rst ? "R9" : "R1", "mc_ready", int'(mc_ready), (m_p == 11) ? 1 : 0);
        t = m_in_rst ? "R9" : ((data && h == 1) ? "R4" : "R2");
        chk(t, "ale", int'(bus_ale), e_ale);
        t = m_in_rst ? "R9" : (data ? "R4" : "R3");
        chk(t, "psen_n", int'(bus_psen_n), e_psen);
        t = m_in_rst ? "R9" : "R5";
        chk(t, "rd_n", int'(bus_rd_n), e_rd);
        chk(t, "wr_n", int'(bus_wr_n), e_wr);
        t = m_in_rst ? "R9" : "R7";
        chk(t, "lo_oe", int'(lo_oe), e_oe);
        chk(t, "lo_out", int'(lo_out), e_lo);
        t = m_in_rst ? "R9" : "R6";
        chk(t, "hi_out", int'(hi_out), e_hi);
        t = m_in_rst ? "R9" : "R8";
        chk(t, "rd_valid", int'(rd_valid), m_vld);
        chk(t, "rd_data", int'(rd_data), m_dat);
        chk(t, "rd_code", int'(rd_code), m_code);
    endtask

    initial begin
        // directed corner cases: kind 0 idle, 1 fetch, 2 read, 3 write
        q.push_back(mk(1, 16'h1234, 0, 0, 8'h00));
        q.push_back(mk(1, 16'h12FF, 1, 0, 8'h00));   // carry into high byte
        q.push_back(mk(2, 16'hABCD, 1, 0, 8'h77));   // wide read
        q.push_back(mk(2, 16'h0055, 0, 0, 8'h3C));   // narrow read: port byte
        q.push_back(mk(3, 16'h8001, 1, 8'hA5, 8'h00));
        q.push_back(mk(3, 16'h00C3, 0, 8'h0F, 8'h5A));
        q.push_back(mk(0, 16'hFFFF, 1, 8'hEE, 8'h99));
        q.push_back(mk(1, 16'hFFFF, 0, 0, 8'h00));   // wrap to 0000
        q.push_back(mk(2, 16'h4000, 1, 0, 8'h00));
        q.push_back(mk(3, 16'h4001, 1, 8'h3D, 8'h00));
        q.push_back(mk(3, 16'h4002, 0, 8'hC2, 8'h81));
        q.push_back(mk(1, 16'h0000, 0, 0, 8'h00));
        for (int i = 0; i < 30; i++)
            q.push_back(mk(i % 4, (i * 16'h1357 + 16'h00F0) & 16'hFFFF, (i / 4) % 2,
                           (i * 43) & 8'hFF, (i * 91 + 5) & 8'hFF));

        m_p = 11; m_cur = mk(0, 0, 0, 0, 8'hFF);
        m_vld = 0; m_dat = 0; m_code = 0; m_in_rst = 1;

        for (int cyc = 0; cyc < 700; cyc++) begin
            bit  rn, cap;
            rq_t nx;
            @(negedge clk);
            compare();
            rn = (cyc < 2) || (cyc == 150) || (cyc == 151);
            rst = rn;
            lo_in = (cyc * 29 + 7) & 8'hFF;
            if (m_p == 11 && !rn) begin
                if (q.size() > 0) nx = q.pop_front();
                else nx = mk(0, 0, 0, 0, 8'h11);
            end else begin
                nx = mk((cyc * 7) % 4, (cyc * 16'h2B1D) & 16'hFFFF, cyc % 2,
                        (cyc * 3) & 8'hFF, (cyc * 5) & 8'hFF);     // ignored, R1
            end
            req_kind = 2'(nx.kind); req_addr = 16'(nx.addr); req_wide = nx.wide[0];
            req_wdata = 8'(nx.wdata); req_p2 = 8'(nx.p2);
            // model the coming edge
            if (rn) begin
                m_p = 11; m_cur = mk(0, 0, 0, 0, 8'hFF);
                m_vld = 0; m_dat = 0; m_code = 0; m_in_rst = 1;
            end else begin
                cap = (m_cur.kind == 1 && (m_p % 6) == 5) || (m_cur.kind == 2 && m_p == 10);
                m_vld = cap ? 1 : 0;
                if (cap) begin
                    m_dat = lo_in; m_code = (m_cur.kind == 1) ? 1 : 0;
                end
                if (m_p == 11) begin
                    m_cur = nx; m_p = 0;
                end else begin
                    m_p = m_p + 1;
                end
                m_in_rst = 0;
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule